// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Table Refill

This block translates a virtual address into a physical address for one requester at a time. The virtual address has two parts. The upper bits form the virtual page number and the lower `OFF_W` bits form the offset inside the page, so a page always holds a power-of-two number of bytes. A small fully associative cache of recent translations is searched on every request. Each cached entry is tagged with an address-space identifier, so translations that belong to different processes can stay in the cache together.

When the cache holds a matching entry, the translation completes in the cycle the request is accepted. When it does not, the block reads one page-table entry from memory at the table base plus the page number scaled by the entry size. It checks the entry's valid and write-protect bits. A usable entry is written into the cache and the translation completes. An unusable entry ends the request with a fault and is not cached. A page number at or beyond the table-length input faults at once, with no memory read.

The request side is valid/ready. A request is taken on any edge where `req_valid` and `req_ready` are both high, and `req_ready` is low while a table read is in flight. The memory request channel is also valid/ready: address and valid stay steady until `mem_req_ready` is seen. The memory response channel and the `done`/`fault` result have no back-pressure. Each is a single-cycle pulse that is consumed when it appears.

Top module: `asid_tlb`

## Requirements
- R1: A successful translation returns `paddr` equal to the frame number concatenated with the request's low `OFF_W` address bits. A faulting one returns `paddr` equal to zero.
- R2: A request whose address-space identifier and page number both match a cached entry completes with `done` high in the same cycle it is accepted, and no memory request is made.
- R3: A cached entry never matches a request that carries a different address-space identifier, even when the page number is the same. Such a request reads the table.
- R4: On a cache miss the block issues exactly one memory read, at address `ptbr + (page number << PTE_SHIFT)`. It raises `done` in the cycle the response arrives and caches the usable entry, so a repeat of the same request hits.
- R5: A page-table entry carries its valid bit in bit 0, its write-protect bit in bit 1 and its frame number in bits `FRAME_W+1:2`. An entry whose valid bit is 0 gives a fault and is not cached, so a repeat of the request reads the table again.
- R6: A write to a page whose write-protect bit is 1 faults, whether the entry comes from the cache or from the table. A read of the same page succeeds. A write that faults on a table read does not cache the entry.
- R7: A page number at or above `ptlr` faults in the cycle of acceptance and starts no memory request.
- R8: A one-cycle `flush` pulse removes every cached entry, so the next request for any page reads the table.
- R9: The cache holds `ENTRIES` (8) translations and replaces them in rotating order. After nine different pages are installed following a flush, the first page misses and the third still hits.
- R10: From the acceptance of a miss until its completion, `busy` is high and `req_ready` is low. An unanswered memory request keeps `mem_req_valid` and `mem_req_addr` steady.
- R11: `fault` is high only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| flush | input | 1 | Drop all cached translations |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Address-space identifier of the requester |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| ptbr | input | PA_W | Base address of the page table |
| ptlr | input | VA_W-OFF_W+1 | Number of pages in the table |
| done | output | 1 | Translation finished this cycle |
| fault | output | 1 | Finished translation was refused |
| paddr | output | PA_W | Physical address, valid with done |
| busy | output | 1 | Table read in progress |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Address of the page-table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | FRAME_W+2 | Page-table entry |

## Verification
On every cycle the assertions check several properties. At most one cached entry matches a lookup. A flush leaves no entry valid on the next cycle. A fault appears only together with completion. A page number out of range never leads to a memory request, and an unanswered memory read holds its address. Only the bench scenarios can show the rest. These cover the translated addresses and the hit or miss decision for a given identifier and page, which is seen through counting memory reads. They also cover the refusal of invalid and write-protected pages, the re-read after a refused entry, and the rotating eviction order once the cache is full.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_REQ,
    WK_WAIT
  } walk_state_e;

  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_WP_BIT    = 1;
  localparam int unsigned PTE_FRAME_LSB = 2;

endpackage

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ptr <= '0;
    end else if (advance) begin
      if (ptr == IDX_W'(ENTRIES - 1)) ptr <= '0;
      else                            ptr <= ptr + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ASID_W  = 4,
  parameter int unsigned VPN_W   = 8,
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_wp,
  input  logic               wr_en,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_wp
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_valid;
  logic [ASID_W-1:0]  ent_asid  [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
  logic [FRAME_W-1:0] ent_frame [ENTRIES];
  logic [ENTRIES-1:0] ent_wp;
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   victim;
  logic               do_write;

  assign do_write = wr_en && !flush;

  tlb_victim_ptr #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush),
    .advance (do_write),
    .ptr     (victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = ent_valid[g] && (ent_asid[g] == lk_asid) && (ent_vpn[g] == lk_vpn);
  end

  always_comb begin
    lk_frame = '0;
    lk_wp    = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_frame = lk_frame | ent_frame[i];
        lk_wp    = lk_wp | ent_wp[i];
      end
    end
  end
  assign lk_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ent_valid <= '0;
    end else if (do_write) begin
      ent_valid[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) begin
      ent_asid[victim]  <= wr_asid;
      ent_vpn[victim]   <= wr_vpn;
      ent_frame[victim] <= wr_frame;
      ent_wp[victim]    <= wr_wp;
    end
  end

  // R3: the identifier and page tag pick at most one entry
  p_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8: a flush leaves nothing cached on the following cycle
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0));

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import asid_tlb_pkg::*;
#(
  parameter int unsigned VPN_W     = 8,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned ASID_W    = 4,
  parameter int unsigned FRAME_W   = 8,
  parameter int unsigned PTE_SHIFT = 2,
  localparam int unsigned PA_W  = FRAME_W + OFF_W,
  localparam int unsigned PTE_W = FRAME_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [ASID_W-1:0]  req_asid,
  input  logic               req_write,
  input  logic [PA_W-1:0]    ptbr,
  input  logic [VPN_W:0]     ptlr,
  input  logic               hit,
  input  logic [FRAME_W-1:0] hit_frame,
  input  logic               hit_wp,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               done,
  output logic               fault,
  output logic [PA_W-1:0]    paddr,
  output logic               busy,
  output logic               ins_en,
  output logic [ASID_W-1:0]  ins_asid,
  output logic [VPN_W-1:0]   ins_vpn,
  output logic [FRAME_W-1:0] ins_frame,
  output logic               ins_wp
);

  walk_state_e        state;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic [ASID_W-1:0]  asid_q;
  logic               write_q;
  logic [PA_W-1:0]    addr_q;
  logic               range_bad;
  logic               start_walk;
  logic               pte_ok;
  logic [FRAME_W-1:0] pte_frame;
  logic               pte_wp;

  assign range_bad  = {1'b0, req_vpn} >= ptlr;
  assign req_ready  = (state == WK_IDLE);
  assign busy       = (state != WK_IDLE);
  assign start_walk = req_valid && req_ready && !range_bad && !hit;

  assign pte_frame = mem_rsp_data[PTE_FRAME_LSB +: FRAME_W];
  assign pte_wp    = mem_rsp_data[PTE_WP_BIT];
  assign pte_ok    = mem_rsp_data[PTE_VALID_BIT] && !(write_q && pte_wp);

  always_comb begin
    done  = 1'b0;
    fault = 1'b0;
    paddr = '0;
    if (state == WK_IDLE && req_valid) begin
      if (range_bad) begin
        done  = 1'b1;
        fault = 1'b1;
      end else if (hit) begin
        done  = 1'b1;
        fault = req_write && hit_wp;
        paddr = fault ? '0 : {hit_frame, req_off};
      end
    end else if (state == WK_WAIT && mem_rsp_valid) begin
      done  = 1'b1;
      fault = !pte_ok;
      paddr = pte_ok ? {pte_frame, off_q} : '0;
    end
  end

  assign ins_en    = (state == WK_WAIT) && mem_rsp_valid && pte_ok;
  assign ins_asid  = asid_q;
  assign ins_vpn   = vpn_q;
  assign ins_frame = pte_frame;
  assign ins_wp    = pte_wp;

  assign mem_req_valid = (state == WK_REQ);
  assign mem_req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WK_IDLE;
    end else begin
      unique case (state)
        WK_IDLE: if (start_walk) state <= WK_REQ;
        WK_REQ:  if (mem_req_ready) state <= WK_WAIT;
        WK_WAIT: if (mem_rsp_valid) state <= WK_IDLE;
        default: state <= WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (start_walk) begin
      vpn_q   <= req_vpn;
      off_q   <= req_off;
      asid_q  <= req_asid;
      write_q <= req_write;
      addr_q  <= ptbr + (PA_W'(req_vpn) << PTE_SHIFT);
    end
  end

  // R10: an unanswered table read keeps its address
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7: an out-of-range page never reaches memory
  p_range_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && range_bad) |=> !mem_req_valid);

  // R11: refusal is only reported with completion
  p_fault_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  // R5: only a valid table entry is ever cached
  p_install_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (mem_rsp_valid && mem_rsp_data[PTE_VALID_BIT]));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned VA_W      = 16,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned ASID_W    = 4,
  parameter int unsigned FRAME_W   = 8,
  parameter int unsigned ENTRIES   = 8,
  parameter int unsigned PTE_SHIFT = 2,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PA_W  = FRAME_W + OFF_W,
  localparam int unsigned PTE_W = FRAME_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  input  logic [PA_W-1:0]   ptbr,
  input  logic [VPN_W:0]    ptlr,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   paddr,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);

  logic [VPN_W-1:0]   vpn;
  logic [OFF_W-1:0]   off;
  logic               hit;
  logic [FRAME_W-1:0] hit_frame;
  logic               hit_wp;
  logic               ins_en;
  logic [ASID_W-1:0]  ins_asid;
  logic [VPN_W-1:0]   ins_vpn;
  logic [FRAME_W-1:0] ins_frame;
  logic               ins_wp;

  assign vpn = req_vaddr[VA_W-1:OFF_W];
  assign off = req_vaddr[OFF_W-1:0];

  tlb_cam #(
    .ENTRIES (ENTRIES),
    .ASID_W  (ASID_W),
    .VPN_W   (VPN_W),
    .FRAME_W (FRAME_W)
  ) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_asid  (req_asid),
    .lk_vpn   (vpn),
    .lk_hit   (hit),
    .lk_frame (hit_frame),
    .lk_wp    (hit_wp),
    .wr_en    (ins_en),
    .wr_asid  (ins_asid),
    .wr_vpn   (ins_vpn),
    .wr_frame (ins_frame),
    .wr_wp    (ins_wp)
  );

  tlb_walker #(
    .VPN_W     (VPN_W),
    .OFF_W     (OFF_W),
    .ASID_W    (ASID_W),
    .FRAME_W   (FRAME_W),
    .PTE_SHIFT (PTE_SHIFT)
  ) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vpn       (vpn),
    .req_off       (off),
    .req_asid      (req_asid),
    .req_write     (req_write),
    .ptbr          (ptbr),
    .ptlr          (ptlr),
    .hit           (hit),
    .hit_frame     (hit_frame),
    .hit_wp        (hit_wp),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr),
    .busy          (busy),
    .ins_en        (ins_en),
    .ins_asid      (ins_asid),
    .ins_vpn       (ins_vpn),
    .ins_frame     (ins_frame),
    .ins_wp        (ins_wp)
  );

  // R2: a hit completes at acceptance, so no table read follows it
  p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit && !flush) |=> !mem_req_valid);

endmodule

// File: tb/asid_tlb_test.sv
module asid_tlb_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_vaddr;
  logic [3:0]  req_asid;
  logic        req_write;
  logic [15:0] ptbr;
  logic [8:0]  ptlr;
  logic        done;
  logic        fault;
  logic [15:0] paddr;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [9:0]  mem_rsp_data;

  int checks = 0;
  int fails  = 0;
  int memreq_count = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  asid_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_asid(req_asid), .req_write(req_write), .ptbr(ptbr), .ptlr(ptlr),
    .done(done), .fault(fault), .paddr(paddr), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // Page-table contents: invalid when page%8==5, write-protected when page%16 is 6 or 12
  function automatic logic [9:0] pte_fn(input logic [15:0] a);
    logic [7:0] x;
    logic [7:0] fr;
    x  = a[9:2];
    fr = x * 8'd29 + {2'b00, a[15:10]};
    return {fr, (x[3:0] == 4'd6 || x[3:0] == 4'd12), (x[2:0] != 3'd5)};
  endfunction

  function automatic logic [15:0] base_of(input logic [3:0] asid);
    return {4'b0, asid[1:0], 10'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model: random ready and response delays, one read per handshake
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (rst_n && mem_req_valid) begin
        logic [15:0] a;
        repeat ($urandom % 3) @(negedge clk);
        a = mem_req_addr;
        mem_req_ready = 1'b1;
        memreq_count++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pte_fn(a);
      end
    end
  end

  task automatic xlate(input logic [7:0] vpn, input logic [7:0] off, input logic [3:0] asid,
                       input bit wr, output logic [15:0] pa, output bit flt,
                       output int lat, output int nreq, output bit saw_busy);
    int n0;
    n0 = memreq_count;
    lat = 0;
    saw_busy = 1'b1;
    pa = '0;
    flt = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_asid  = asid;
    req_write = wr;
    ptbr      = base_of(asid);
    #1;
    if (done) begin
      pa = paddr;
      flt = fault;
      @(negedge clk);
      req_valid = 1'b0;
    end else begin
      @(negedge clk);
      req_valid = 1'b0;
      forever begin
        #1;
        lat++;
        if (done) begin
          pa = paddr;
          flt = fault;
          break;
        end
        saw_busy &= (busy && !req_ready);
        if (lat > 60) begin
          chk(1'b0, "R10", "watchdog on walk", lat, 60);
          break;
        end
        @(negedge clk);
      end
    end
    nreq = memreq_count - n0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // Expected result computed from the page-table function and the requirements
  task automatic expect_of(input logic [7:0] vpn, input logic [7:0] off, input logic [3:0] asid,
                           input bit wr, output logic [15:0] pa, output bit flt);
    logic [9:0] e;
    e = pte_fn(base_of(asid) + {6'b0, vpn, 2'b00});
    if ({1'b0, vpn} >= ptlr || !e[0] || (wr && e[1])) begin
      flt = 1'b1;
      pa = '0;
    end else begin
      flt = 1'b0;
      pa = {e[9:2], off};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pa, epa;
    bit flt, eflt, sb;
    int lat, nreq;
    logic [7:0] r9_pages [9];

    void'($urandom(32'd20240415));
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    req_asid = '0; req_write = 1'b0; ptbr = '0; ptlr = 9'd200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!busy && !done && !mem_req_valid && req_ready, "R10", "reset state",
        {busy, done, mem_req_valid, req_ready}, 4'b0001);

    // R4 + R1: miss reads table once, correct address
    xlate(8'd3, 8'h5a, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    expect_of(8'd3, 8'h5a, 4'd1, 1'b0, epa, eflt);
    chk(pa == epa && !flt, "R1", "miss translation", pa, epa);
    chk(nreq == 1, "R4", "reads on miss", nreq, 1);
    chk(sb, "R10", "busy and not ready during walk", sb, 1);
    // R2: repeat hits in acceptance cycle
    xlate(8'd3, 8'h11, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    expect_of(8'd3, 8'h11, 4'd1, 1'b0, epa, eflt);
    chk(nreq == 0 && lat == 0, "R2", "hit latency/reads", {lat[7:0], nreq[7:0]}, 0);
    chk(pa == epa, "R1", "hit translation", pa, epa);
    // R3: other identifier, same page, reads table
    xlate(8'd3, 8'h11, 4'd2, 1'b0, pa, flt, lat, nreq, sb);
    expect_of(8'd3, 8'h11, 4'd2, 1'b0, epa, eflt);
    chk(nreq == 1, "R3", "reads for other identifier", nreq, 1);
    chk(pa == epa, "R3", "other identifier translation", pa, epa);

    // R7: range boundary
    xlate(8'd200, 8'h00, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    chk(flt && nreq == 0 && lat == 0 && pa == 0, "R7", "page at length", {flt, nreq[3:0]}, 5'h10);
    xlate(8'd199, 8'h00, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    chk(!flt && nreq == 1, "R7", "last page in range", {flt, nreq[3:0]}, 5'h01);

    // R5: invalid entry faults and is not cached
    xlate(8'd5, 8'h01, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    chk(flt && nreq == 1 && pa == 0, "R5", "invalid entry", {flt, nreq[3:0]}, 5'h11);
    xlate(8'd5, 8'h01, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    chk(flt && nreq == 1, "R5", "invalid entry read again", {flt, nreq[3:0]}, 5'h11);

    // R6: write-protected page
    xlate(8'd6, 8'h02, 4'd1, 1'b1, pa, flt, lat, nreq, sb);
    chk(flt && nreq == 1 && pa == 0, "R6", "write on walk", {flt, nreq[3:0]}, 5'h11);
    xlate(8'd6, 8'h02, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    expect_of(8'd6, 8'h02, 4'd1, 1'b0, epa, eflt);
    chk(!flt && nreq == 1 && pa == epa, "R6", "read after refused write", pa, epa);
    xlate(8'd6, 8'h02, 4'd1, 1'b1, pa, flt, lat, nreq, sb);
    chk(flt && nreq == 0 && lat == 0, "R6", "write on hit", {flt, nreq[3:0]}, 5'h10);

    // R8: flush drops all entries
    do_flush();
    xlate(8'd3, 8'h11, 4'd1, 1'b0, pa, flt, lat, nreq, sb);
    chk(nreq == 1, "R8", "read after flush", nreq, 1);

    // R9: rotating replacement
    r9_pages = '{8'd16, 8'd17, 8'd18, 8'd19, 8'd20, 8'd22, 8'd23, 8'd24, 8'd25};
    do_flush();
    foreach (r9_pages[i]) xlate(r9_pages[i], 8'h00, 4'd3, 1'b0, pa, flt, lat, nreq, sb);
    xlate(r9_pages[0], 8'h00, 4'd3, 1'b0, pa, flt, lat, nreq, sb);
    chk(nreq == 1, "R9", "oldest evicted", nreq, 1);
    xlate(r9_pages[2], 8'h00, 4'd3, 1'b0, pa, flt, lat, nreq, sb);
    chk(nreq == 0, "R9", "third still cached", nreq, 0);

    // Random traffic: R1 R4 R5 R6 R7 end-to-end
    for (int it = 0; it < 400; it++) begin
      logic [7:0] v, o;
      logic [3:0] a;
      bit w;
      v = 8'($urandom % 224);
      o = 8'($urandom);
      a = 4'($urandom % 4);
      w = ($urandom % 4) == 0;
      if ($urandom % 25 == 0) do_flush();
      xlate(v, o, a, w, pa, flt, lat, nreq, sb);
      expect_of(v, o, a, w, epa, eflt);
      chk(pa == epa && flt == eflt, "R1", "random translation", {flt, pa}, {eflt, epa});
      chk(nreq <= 1, "R4", "at most one read", nreq, 1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule